// File: doc/BRIEF.md
# Audio Control Register Write Port over I2C

This block is a write-only I2C target that lets a host microcontroller load a bank of eight 8-bit control registers belonging to an audio processing chip. The bus lines arrive as raw oversampled levels; the block synchronizes them to the system clock, finds start and stop conditions, shifts in bytes and answers each accepted byte by pulling SDA low. The SDA output is a pull-down enable for an external open-drain pad.

A transfer is a start, the device address byte (write only), one subaddress byte, then any number of data bytes and a stop. The subaddress picks a register and carries a flag that chooses between rewriting one register for every data byte and stepping a 4-bit pointer after each byte. The eight register values leave the block as one flat bus, together with an effective bass level-control enable that is held off while the bass setting is a cut.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: A stop condition (SDA rising while SCL is high) ends the transfer; bytes clocked afterwards without a new start get no acknowledge and change no register.
- R2: Only the address byte 0x88 (7-bit address 1000100, write bit 0) is acknowledged; any other address byte, including the read form 0x89, gets no acknowledge, and the block then ignores the bus until the next start condition.
- R3: After each accepted byte the block pulls SDA low for the whole ninth clock and releases it on the SCL falling edge that ends that clock; at no other time does it pull SDA.
- R4: In the subaddress byte, bits 3:0 pick the register (subaddress n drives bits 8n+7 down to 8n of `regs_o`), bit 4 is the step flag and bits 7:5 have no effect.
- R5: With the step flag clear, every data byte of the transfer lands in the same selected register, so the last one wins.
- R6: With the step flag set, the first data byte goes to the selected register and each later byte to the next slot of a 16-slot space that wraps from 15 to 0; bytes aimed at slots 8 to 15 are acknowledged but stored nowhere.
- R7: After reset every register reads 0xFE.
- R8: `alc_eff_o` equals bit 0 of register 7 AND bit 7 of register 5; when bit 7 of register 5 is 0 (a bass cut setting) the output is 0 whatever register 7 holds.
- R9: A start condition seen in the middle of a transfer (repeated start) restarts reception at the address byte, discarding the partial state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL level from the bus |
| sda_i | input | 1 | Raw SDA level from the bus |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| regs_o | output | 64 | Eight control registers, register n in bits 8n+7:8n |
| alc_eff_o | output | 1 | Effective bass level-control enable |

## Verification
Every bus edge reaches the byte engine three system clocks after it appears on a pin (two synchronizer flops plus the edge-detect flop), the acknowledge pull-down follows one clock later, a committed data byte shows on `regs_o` two clocks after the acknowledge clock's rising edge is seen, and `alc_eff_o` one clock after that. The bench holds every SCL and SDA level for eight system clocks, reads the acknowledge in the middle of the ninth clock's high phase, checks the release eight clocks after that clock falls, and compares registers only after the stop condition has settled, so each sample lands well after the latest of these latencies.

// File: rtl/acs_pkg.sv
package acs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_IGNORE
  } bus_st_t;

endpackage

// File: rtl/acs_sync_edge.sv
module acs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];

endmodule

// File: rtl/acs_byte_fsm.sv
module acs_byte_fsm
  import acs_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          PTR_W     = 4,
  parameter logic [7:0]  ADDR_BYTE = 8'h88
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_pull,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [DW-1:0]    wr_data
);

  localparam int CNT_W   = $clog2(DW + 1);
  localparam int INC_BIT = PTR_W;

  bus_st_t          state;
  logic [CNT_W-1:0] bcnt;
  logic [DW-1:0]    shreg;
  logic             ack_ph;
  logic             pend;
  logic             inc;
  logic [PTR_W-1:0] ptr;
  logic             active;

  assign active = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bcnt     <= '0;
      shreg    <= '0;
      ack_ph   <= 1'b0;
      pend     <= 1'b0;
      inc      <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bcnt     <= '0;
        ack_ph   <= 1'b0;
        pend     <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        bcnt     <= '0;
        ack_ph   <= 1'b0;
        pend     <= 1'b0;
        sda_pull <= 1'b0;
      end else if (scl_rise) begin
        if (ack_ph) begin
          if (pend) begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= shreg;
            pend    <= 1'b0;
            if (inc) ptr <= ptr + PTR_W'(1);
          end
        end else if (active && (bcnt < CNT_W'(DW))) begin
          shreg <= {shreg[DW-2:0], sda_lvl};
          bcnt  <= bcnt + CNT_W'(1);
        end
      end else if (scl_fall) begin
        if (ack_ph) begin
          ack_ph   <= 1'b0;
          sda_pull <= 1'b0;
        end else if (active && (bcnt == CNT_W'(DW))) begin
          bcnt <= '0;
          unique case (state)
            ST_ADDR: begin
              if (shreg == ADDR_BYTE) begin
                state    <= ST_SUB;
                ack_ph   <= 1'b1;
                sda_pull <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_SUB: begin
              ptr      <= shreg[PTR_W-1:0];
              inc      <= shreg[INC_BIT];
              state    <= ST_DATA;
              ack_ph   <= 1'b1;
              sda_pull <= 1'b1;
            end
            default: begin
              pend     <= 1'b1;
              ack_ph   <= 1'b1;
              sda_pull <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R9: a start always restarts address reception with a clean bit count
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && bcnt == '0 && !sda_pull));

  // R1: a stop returns the engine to idle with SDA released
  a_r1_stop_idles: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_pull));

  // R2: once an address is refused the bus is never pulled
  a_r2_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_pull);

  // R3: release only follows an SCL fall or a bus condition
  a_r3_release_edge: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det));

  // R6: stepping mode advances the pointer past each write
  a_r6_ptr_steps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && inc) |-> (ptr == (wr_addr + PTR_W'(1))));

  // R5: fixed mode keeps the pointer on the written register
  a_r5_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !inc) |-> (ptr == wr_addr));

endmodule

// File: rtl/acs_regfile.sv
module acs_regfile #(
  parameter int         NREG    = 8,
  parameter int         DW      = 8,
  parameter int         AW      = 4,
  parameter logic [7:0] RST_VAL = 8'hFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NREG*DW-1:0] regs_flat
);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= DW'(RST_VAL);
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (wr_addr == AW'(i)) mem[i] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = mem[g];
  end

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R7: every register holds the reset value right after reset
  a_r7_reset_value: assert property (@(posedge clk)
    rst_q |-> (regs_flat == {NREG{DW'(RST_VAL)}}));

  // R6: writes aimed beyond the bank leave all registers untouched
  a_r6_high_slot_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr >= AW'(NREG))) |=> $stable(regs_flat));

endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave #(
  parameter logic [7:0] DEV_ADDR     = 8'h88,
  parameter int         NREG         = 8,
  parameter int         DW           = 8,
  parameter int         PTR_W        = 4,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] RST_VAL      = 8'hFE,
  parameter int         BASS_REG     = 5,
  parameter int         BASS_CUT_BIT = 7,
  parameter int         ALC_REG      = 7,
  parameter int         ALC_EN_BIT   = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [NREG*DW-1:0] regs_o,
  output logic               alc_eff_o
);

  localparam int BASS_IDX = BASS_REG * DW + BASS_CUT_BIT;
  localparam int ALC_IDX  = ALC_REG * DW + ALC_EN_BIT;

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic [DW-1:0]    wr_data;

  acs_sync_edge #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .din(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
  );

  acs_sync_edge #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .din(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
  );

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;

  acs_byte_fsm #(.DW(DW), .PTR_W(PTR_W), .ADDR_BYTE(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  acs_regfile #(.NREG(NREG), .DW(DW), .AW(PTR_W), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .regs_flat(regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) alc_eff_o <= 1'b0;
    else     alc_eff_o <= regs_o[ALC_IDX] & regs_o[BASS_IDX];
  end

  // R3: the pull-down is only switched on while SCL is low
  a_r3_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_lvl);

  // R8: a bass cut setting forces the effective enable off
  a_r8_cut_forces_off: assert property (@(posedge clk) disable iff (rst)
    !regs_o[BASS_IDX] |=> !alc_eff_o);

endmodule

// File: tb/audio_ctl_i2c_slave_tb_top.sv
module audio_ctl_i2c_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_pull;
  logic [63:0] regs;
  logic        alc_eff;
  logic        sda_line;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] exp_r [8];

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_ctl_i2c_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .regs_o(regs), .alc_eff_o(alc_eff)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_line;
    wq();
    scl_m = 1'b0; wq();
    chk(req, ack, exp_ack);
    // R3: released once the ninth clock has fallen
    chk("R3 release", sda_pull, 1'b0);
  endtask

  task automatic check_regs(input string req);
    chk(req, regs, {exp_r[7], exp_r[6], exp_r[5], exp_r[4],
                    exp_r[3], exp_r[2], exp_r[1], exp_r[0]});
    chk("R8 alc", alc_eff, exp_r[7][0] & exp_r[5][7]);
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 8; i++) exp_r[i] = 8'hFE;
    check_regs("R7 reset value");
    chk("R3 idle pull", sda_pull, 1'b0);
  endtask

  task automatic t_single_write();
    bus_start();
    send_byte(8'h88, 1'b1, "R2 addr ack");
    send_byte(8'hE3, 1'b1, "R4 sub ack");
    send_byte(8'h12, 1'b1, "R3 data ack");
    bus_stop();
    exp_r[3] = 8'h12;
    check_regs("R4 subaddress select");
  endtask

  task automatic t_fixed_ptr();
    bus_start();
    send_byte(8'h88, 1'b1, "R5 addr ack");
    send_byte(8'h01, 1'b1, "R5 sub ack");
    send_byte(8'h11, 1'b1, "R5 data ack");
    send_byte(8'h22, 1'b1, "R5 data ack");
    send_byte(8'h33, 1'b1, "R5 data ack");
    bus_stop();
    exp_r[1] = 8'h33;
    check_regs("R5 fixed pointer");
  endtask

  task automatic t_auto_inc();
    bus_start();
    send_byte(8'h88, 1'b1, "R6 addr ack");
    send_byte(8'h16, 1'b1, "R6 sub ack");
    for (int i = 0; i < 11; i++) send_byte(8'h40 + 8'(i), 1'b1, "R6 data ack");
    bus_stop();
    exp_r[6] = 8'h40;
    exp_r[7] = 8'h41;
    exp_r[0] = 8'h4A;
    check_regs("R6 step and wrap");
  endtask

  task automatic t_alc_cut();
    bus_start();
    send_byte(8'h88, 1'b1, "R8 addr ack");
    send_byte(8'h05, 1'b1, "R8 sub ack");
    send_byte(8'h7F, 1'b1, "R8 data ack");
    bus_stop();
    exp_r[5] = 8'h7F;
    check_regs("R8 cut forces off");
    chk("R8 cut alc", alc_eff, 1'b0);
    bus_start();
    send_byte(8'h88, 1'b1, "R8 addr ack");
    send_byte(8'h05, 1'b1, "R8 sub ack");
    send_byte(8'h80, 1'b1, "R8 data ack");
    bus_stop();
    exp_r[5] = 8'h80;
    check_regs("R8 boost allows on");
    chk("R8 boost alc", alc_eff, 1'b1);
  endtask

  task automatic t_bad_addr();
    bus_start();
    send_byte(8'h8A, 1'b0, "R2 wrong addr nack");
    send_byte(8'h00, 1'b0, "R2 ignored byte");
    send_byte(8'h99, 1'b0, "R2 ignored byte");
    bus_stop();
    bus_start();
    send_byte(8'h89, 1'b0, "R2 read bit nack");
    send_byte(8'h02, 1'b0, "R2 ignored byte");
    send_byte(8'h5A, 1'b0, "R2 ignored byte");
    bus_stop();
    check_regs("R2 no write after refusal");
  endtask

  task automatic t_repeated_start();
    bus_start();
    send_byte(8'h88, 1'b1, "R9 addr ack");
    send_byte(8'h00, 1'b1, "R9 sub ack");
    for (int i = 7; i >= 4; i--) begin
      sda_m = i[0]; wq();
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq();
    end
    bus_start();
    send_byte(8'h88, 1'b1, "R9 restart addr ack");
    send_byte(8'h04, 1'b1, "R9 sub ack");
    send_byte(8'h55, 1'b1, "R9 data ack");
    bus_stop();
    exp_r[4] = 8'h55;
    check_regs("R9 repeated start");
  endtask

  task automatic t_stop_idle();
    send_byte(8'h88, 1'b0, "R1 no start nack");
    send_byte(8'h02, 1'b0, "R1 no start nack");
    send_byte(8'hAA, 1'b0, "R1 no start nack");
    bus_stop();
    check_regs("R1 idle after stop");
    bus_start();
    send_byte(8'h88, 1'b1, "R1 fresh start ack");
    send_byte(8'h02, 1'b1, "R1 sub ack");
    send_byte(8'hC3, 1'b1, "R1 data ack");
    bus_stop();
    exp_r[2] = 8'hC3;
    check_regs("R1 write after new start");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset_state();
    t_single_write();
    t_fixed_ptr();
    t_auto_inc();
    t_alc_cut();
    t_bad_addr();
    t_repeated_start();
    t_stop_idle();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule